// File: doc/BRIEF.md
# Transmit Jabber, Heartbeat and Activity Indicator Supervisor

This block watches the transmit-enable line of a twisted-pair port, clocked at 20 MHz. When transmit enable is held on for too long, it cuts off the transmitter. It keeps the transmitter cut off until the line has stayed quiet for a much longer time. While the transmitter is cut off, the collision output is held high. In twisted-pair mode, the block also does two things on the collision output. It places a short heartbeat pulse there a fixed time after each frame ends. It also raises the output whenever receive carrier is seen during a transmission.

Two active-low indicator lines show transmit and receive activity. Each one stays lit for a stretch of time after its activity stops. Both lines light together for two-thirds of a second after reset, as a lamp test. All long intervals are counted in clock ticks. A speedup input divides the long intervals by a power of two, so board or bench tests can run quickly. The heartbeat timing is never shortened.

Top module: `txe_supervisor`

## Requirements
- R1: Jabber trip. `tx_inhibit` rises on the clock edge that samples `txe` high for the JAB-th consecutive time. It is still low after JAB-1 such edges. JAB is 840000 ticks, or 840000>>10 = 820 ticks when `speedup` is 1.
- R2: While `tx_inhibit` is high, `col` is high.
- R3: Release. Once tripped, `tx_inhibit` falls on the edge that samples `txe` low for the REL-th consecutive time. Any edge that samples `txe` high restarts this count. REL is 6800000 ticks, or 6640 ticks with `speedup`.
- R4: Heartbeat. Let E0 be the first edge that samples `txe` low after it was high, with `tp_mode` high and not tripped. `col` is high after edges E20 through E39, and low after E19 and after E40. The 20-tick delay and the 20-tick width ignore `speedup`.
- R5: No heartbeat is produced when `tp_mode` is low. No heartbeat is produced when `txe` falls while `tx_inhibit` is high.
- R6: True collision. An edge that samples `tp_mode`, `txe` and `crs` all high sets `col` high after that edge. With `tp_mode` low, `crs` during transmit does not raise `col`.
- R7: Lamp test. `led_tx_n` and `led_rx_n` are low during reset. After reset, they stay low for LAMP edges (13340000, or 13027 with `speedup`), then go high when idle.
- R8: Stretch. An indicator goes low after an edge that samples its activity (`txe` for transmit, `crs` for receive). It stays low until STR consecutive edges have sampled the activity low, then goes high. STR is 1000000, or 976 with `speedup`.
- R9: With `speedup` low, the nominal interval applies. Holding `txe` high for 2000 edges does not trip the jabber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz tick clock |
| rst_n | input | 1 | synchronous active-low reset |
| txe | input | 1 | transmit enable from the controller |
| crs | input | 1 | receive carrier present |
| tp_mode | input | 1 | high when the twisted-pair medium is selected |
| speedup | input | 1 | shortens the long intervals for test |
| col | output | 1 | collision: jabber, heartbeat or true collision |
| tx_inhibit | output | 1 | high while the twisted-pair transmitter is cut off |
| led_tx_n | output | 1 | transmit activity indicator, active low |
| led_rx_n | output | 1 | receive activity indicator, active low |

## Verification
The hardest state to reach is jabber release with a restarted quiet interval. At nominal rates this takes millions of ticks. The bench therefore raises `speedup`, holds `txe` past the scaled trip count and then lets it fall. Just short of the release count, it injects a one-tick `txe` pulse. It then checks two things: the inhibit survives a full further quiet count minus one, and the short pulse ending under inhibit produces no heartbeat.

// File: rtl/txsup_pkg.sv
// Package: shared helpers for the transmit supervisor.
// Converts time spans into clock ticks and defines the heartbeat states.
package txsup_pkg;

    // Ticks in a span given in milliseconds
    function automatic int unsigned ms_ticks(input int unsigned clk_khz, input int unsigned ms);
        return clk_khz * ms;
    endfunction

    // Ticks in a span given in nanoseconds
    function automatic int unsigned ns_ticks(input int unsigned clk_khz, input int unsigned ns);
        return (clk_khz * ns) / 1000000;
    endfunction

    // Speedup scaling, never below one tick
    function automatic int unsigned scaled(input int unsigned n, input int unsigned shift);
        return ((n >> shift) == 0) ? 1 : (n >> shift);
    endfunction

    // Larger of two counts
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_t;

endpackage

// File: rtl/txsup_span_counter.sv
// Module: span counter.
// Counts edges on which `advance` is high. `hit` flags the edge that
// completes `limit` counts, and the count then wraps to zero.
// Assumes limit >= 1. `clear` has priority over `advance`.
module txsup_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Terminal-count detect on the current edge
    always_comb begin
        hit = advance && !clear && (cnt == limit - 1'b1);
    end

    // Count register with clear and wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/txsup_jabber.sv
// Module: jabber guard.
// Trips after TRIP consecutive edges that sample txe high. It releases
// after REL consecutive edges that sample txe low. Assumes txe is
// already synchronous to clk.
module txsup_jabber #(
    parameter int unsigned TRIP   = 840000,
    parameter int unsigned TRIP_S = 820,
    parameter int unsigned REL    = 6800000,
    parameter int unsigned REL_S  = 6640,
    parameter int          W      = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txe,
    input  logic speedup,
    output logic jabbered
);
    logic [W-1:0] trip_lim, rel_lim;
    logic         trip_hit, rel_hit;

    // Pick the nominal or the shortened window
    always_comb begin
        trip_lim = speedup ? W'(TRIP_S) : W'(TRIP);
        rel_lim  = speedup ? W'(REL_S)  : W'(REL);
    end

    txsup_span_counter #(.W(W)) u_trip (
        .clk(clk), .rst_n(rst_n),
        .clear(!txe || jabbered), .advance(txe && !jabbered),
        .limit(trip_lim), .hit(trip_hit)
    );

    txsup_span_counter #(.W(W)) u_rel (
        .clk(clk), .rst_n(rst_n),
        .clear(txe || !jabbered), .advance(!txe && jabbered),
        .limit(rel_lim), .hit(rel_hit)
    );

    // Jabber state: set on trip, cleared on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jabbered <= 1'b0;
        end else if (trip_hit) begin
            jabbered <= 1'b1;
        end else if (rel_hit) begin
            jabbered <= 1'b0;
        end
    end
endmodule

// File: rtl/txsup_heartbeat.sv
// Module: heartbeat generator.
// On a sampled falling edge of txe, in twisted-pair mode and with no
// jabber, it waits DLY ticks and then pulses for WID ticks. A new frame
// end that arrives during a pulse sequence is ignored.
module txsup_heartbeat #(
    parameter int unsigned DLY = 20,
    parameter int unsigned WID = 20,
    parameter int          W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txe,
    input  logic tp_mode,
    input  logic jabbered,
    output logic pulse
);
    import txsup_pkg::*;

    hb_state_t    state;
    logic         txe_d;
    logic         frame_end;
    logic         hit;
    logic [W-1:0] lim;

    // Frame end detect and phase limit select
    always_comb begin
        frame_end = txe_d && !txe && tp_mode && !jabbered;
        lim       = (state == HB_WAIT) ? W'(DLY) : W'(WID);
        pulse     = (state == HB_PULSE);
    end

    txsup_span_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(state == HB_IDLE), .advance(state != HB_IDLE),
        .limit(lim), .hit(hit)
    );

    // Previous txe sample for edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) txe_d <= 1'b0;
        else        txe_d <= txe;
    end

    // Delay then pulse sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HB_IDLE;
        end else begin
            unique case (state)
                HB_IDLE:  if (frame_end) state <= HB_WAIT;
                HB_WAIT:  if (hit)       state <= HB_PULSE;
                HB_PULSE: if (hit)       state <= HB_IDLE;
                default:                 state <= HB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txsup_indicator.sv
// Module: activity stretcher.
// Lights on any sampled activity. It stays lit until STR consecutive
// edges have seen no activity.
module txsup_indicator #(
    parameter int unsigned STR   = 1000000,
    parameter int unsigned STR_S = 976,
    parameter int          W     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic speedup,
    output logic lit
);
    logic [W-1:0] lim;
    logic         hit;

    // Window select
    always_comb lim = speedup ? W'(STR_S) : W'(STR);

    txsup_span_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clear(act || !lit), .advance(!act && lit),
        .limit(lim), .hit(hit)
    );

    // Lit flag: set by activity, cleared when the stretch expires
    always_ff @(posedge clk) begin
        if (!rst_n)   lit <= 1'b0;
        else if (act) lit <= 1'b1;
        else if (hit) lit <= 1'b0;
    end
endmodule

// File: rtl/txe_supervisor.sv
// Module: transmit supervisor top.
// Combines jabber protection, heartbeat, true-collision merging,
// activity indicators and the power-up lamp test. All inputs are
// assumed synchronous to the 20 MHz clk.
module txe_supervisor #(
    parameter int unsigned CLK_KHZ     = 20000,
    parameter int unsigned JAB_MS      = 42,
    parameter int unsigned REL_MS      = 340,
    parameter int unsigned STRETCH_MS  = 50,
    parameter int unsigned LAMP_MS     = 667,
    parameter int unsigned HB_DLY_NS   = 1000,
    parameter int unsigned HB_WID_NS   = 1000,
    parameter int unsigned SPEED_SHIFT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txe,
    input  logic crs,
    input  logic tp_mode,
    input  logic speedup,
    output logic col,
    output logic tx_inhibit,
    output logic led_tx_n,
    output logic led_rx_n
);
    import txsup_pkg::*;

    localparam int unsigned JAB_T  = ms_ticks(CLK_KHZ, JAB_MS);
    localparam int unsigned REL_T  = ms_ticks(CLK_KHZ, REL_MS);
    localparam int unsigned STR_T  = ms_ticks(CLK_KHZ, STRETCH_MS);
    localparam int unsigned LAMP_T = ms_ticks(CLK_KHZ, LAMP_MS);
    localparam int unsigned DLY_T  = ns_ticks(CLK_KHZ, HB_DLY_NS);
    localparam int unsigned WID_T  = ns_ticks(CLK_KHZ, HB_WID_NS);
    localparam int          JW     = $clog2(max2(JAB_T, REL_T) + 1);
    localparam int          SW     = $clog2(STR_T + 1);
    localparam int          LW     = $clog2(LAMP_T + 1);
    localparam int          HW     = $clog2(max2(DLY_T, WID_T) + 1);
    localparam int          NCH    = 2;

    logic           jab, hb, coll_q, lamp_q, lamp_hit;
    logic [NCH-1:0] act, lit;
    logic [LW-1:0]  lamp_lim;

    txsup_jabber #(
        .TRIP(JAB_T), .TRIP_S(scaled(JAB_T, SPEED_SHIFT)),
        .REL(REL_T),  .REL_S(scaled(REL_T, SPEED_SHIFT)), .W(JW)
    ) u_jab (
        .clk(clk), .rst_n(rst_n), .txe(txe), .speedup(speedup), .jabbered(jab)
    );

    txsup_heartbeat #(.DLY(DLY_T), .WID(WID_T), .W(HW)) u_hb (
        .clk(clk), .rst_n(rst_n), .txe(txe), .tp_mode(tp_mode),
        .jabbered(jab), .pulse(hb)
    );

    // Receive-during-transmit collision, twisted-pair only
    always_ff @(posedge clk) begin
        if (!rst_n) coll_q <= 1'b0;
        else        coll_q <= tp_mode && txe && crs;
    end

    // Activity sources: bit 0 transmit, bit 1 receive
    always_comb act = {crs, txe};

    for (genvar g = 0; g < NCH; g++) begin : g_ind
        txsup_indicator #(
            .STR(STR_T), .STR_S(scaled(STR_T, SPEED_SHIFT)), .W(SW)
        ) u_ind (
            .clk(clk), .rst_n(rst_n), .act(act[g]), .speedup(speedup), .lit(lit[g])
        );
    end

    // Lamp window select
    always_comb lamp_lim = speedup ? LW'(scaled(LAMP_T, SPEED_SHIFT)) : LW'(LAMP_T);

    txsup_span_counter #(.W(LW)) u_lamp (
        .clk(clk), .rst_n(rst_n), .clear(1'b0), .advance(lamp_q),
        .limit(lamp_lim), .hit(lamp_hit)
    );

    // Lamp test flag: on from reset until its window ends
    always_ff @(posedge clk) begin
        if (!rst_n)        lamp_q <= 1'b1;
        else if (lamp_hit) lamp_q <= 1'b0;
    end

    // Output merge
    always_comb begin
        col        = jab || hb || coll_q;
        tx_inhibit = jab;
        led_tx_n   = !(lit[0] || lamp_q);
        led_rx_n   = !(lit[1] || lamp_q);
    end
endmodule

// File: rtl/txe_supervisor_chk.sv
// Module: property checker for the transmit supervisor, bound to the top.
module txe_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic txe,
    input logic crs,
    input logic tp_mode,
    input logic col,
    input logic tx_inhibit,
    input logic led_tx_n,
    input logic led_rx_n
);
    // R2: inhibit holds collision high
    a_r2_inhibit_col: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> col);

    // R1: trip only while transmitting
    a_r1_trip_on_txe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> $past(txe));

    // R3: release only after a quiet sample
    a_r3_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_inhibit) |-> !$past(txe));

    // R6: receive during transmit in twisted-pair mode
    a_r6_true_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_mode && txe && crs) |=> col);

    // R8: indicators light after activity
    a_r8_tx_lit: assert property (@(posedge clk) disable iff (!rst_n)
        txe |=> !led_tx_n);
    a_r8_rx_lit: assert property (@(posedge clk) disable iff (!rst_n)
        crs |=> !led_rx_n);
endmodule

bind txe_supervisor txe_supervisor_chk u_chk (.*);

// File: tb/tb_txe_supervisor.sv
module tb_txe_supervisor;
    logic clk = 1'b0;
    logic rst_n, txe, crs, tp_mode, speedup;
    logic col, tx_inhibit, led_tx_n, led_rx_n;
    int   n_chk = 0, n_fail = 0;

    localparam int JAB  = (42 * 20000) >> 10;
    localparam int REL  = (340 * 20000) >> 10;
    localparam int STR  = (50 * 20000) >> 10;
    localparam int LAMP = (667 * 20000) >> 10;

    always #2 clk = ~clk;

    txe_supervisor dut (.*);

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset_lamp();
        rst_n = 0; txe = 0; crs = 0; tp_mode = 1; speedup = 1;
        step(4);
        check(col, 0, "R2 reset col");
        check(tx_inhibit, 0, "R1 reset inhibit");
        check(led_tx_n, 0, "R7 lamp tx in reset");
        check(led_rx_n, 0, "R7 lamp rx in reset");
        rst_n = 1;
        step(LAMP - 1);
        check(led_tx_n, 0, "R7 lamp tx before end");
        step(1);
        check(led_tx_n, 1, "R7 lamp tx off");
        check(led_rx_n, 1, "R7 lamp rx off");
    endtask

    task automatic t_heartbeat();
        txe = 1; step(10);
        txe = 0; step(1);
        check(col, 0, "R4 col at E0");
        step(19); check(col, 0, "R4 col after E19");
        step(1);  check(col, 1, "R4 col after E20");
        step(19); check(col, 1, "R4 col after E39");
        step(1);  check(col, 0, "R4 col after E40");
        step(STR - 1 - 41); check(led_tx_n, 0, "R8 tx led still lit");
        step(1);  check(led_tx_n, 1, "R8 tx led off");
    endtask

    task automatic t_rx_led();
        crs = 1; step(1);
        check(led_rx_n, 0, "R8 rx led lit");
        check(col, 0, "R6 no col without txe");
        crs = 0; step(STR - 1);
        check(led_rx_n, 0, "R8 rx led stretched");
        step(1); check(led_rx_n, 1, "R8 rx led off");
    endtask

    task automatic t_collision();
        txe = 1; crs = 1; step(1);
        check(col, 1, "R6 true collision");
        crs = 0; step(1);
        check(col, 0, "R6 collision ends");
        txe = 0; step(60);
    endtask

    task automatic t_aui();
        logic seen = 0;
        tp_mode = 0; txe = 1; crs = 1; step(1);
        check(col, 0, "R6 no collision in aui");
        crs = 0; step(5); txe = 0;
        for (int i = 0; i < 60; i++) begin step(1); seen |= col; end
        check(seen, 0, "R5 no heartbeat in aui");
        tp_mode = 1;
    endtask

    task automatic t_jabber();
        logic seen = 0;
        txe = 1; step(JAB - 1);
        check(tx_inhibit, 0, "R1 not tripped at JAB-1");
        step(1);
        check(tx_inhibit, 1, "R1 tripped at JAB");
        check(col, 1, "R2 col while inhibited");
        txe = 0; step(REL - 1);
        check(tx_inhibit, 1, "R3 held before pulse");
        txe = 1; step(1); txe = 0;
        step(REL - 1);
        check(tx_inhibit, 1, "R3 count restarted");
        check(col, 1, "R2 col still high");
        step(1);
        check(tx_inhibit, 0, "R3 released");
        for (int i = 0; i < 60; i++) begin step(1); seen |= col; end
        check(seen, 0, "R5 no heartbeat after jabber end");
    endtask

    task automatic t_nominal();
        speedup = 0; txe = 1; step(2000);
        check(tx_inhibit, 0, "R9 nominal no trip");
        txe = 0; step(60); speedup = 1;
    endtask

    initial begin
        t_reset_lamp();
        t_heartbeat();
        t_rx_led();
        t_collision();
        t_aui();
        t_jabber();
        t_nominal();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule